// File: doc/BRIEF.md
# Two-Group Masked Interrupt Aggregator

This block collects a set of level-sensitive interrupt lines from peripherals and reduces them to two request lines for a processor. One line is a fast request, driven by a small fixed group of sources. The other is a normal request, driven by the remaining larger group. The processor's exception logic treats the fast request as more urgent than the normal one. Inside a group the hardware does not rank sources. Software reads the status register to learn which source is pending and decides the order of service itself.

Each source has an enable bit in a mask register. A request line is raised only while at least one source of its group is both active and enabled. Most sources are plain levels, so the source device holds its line until its service routine clears the cause at the device. A parameter marks some sources as end-of-interrupt sources. Each of these is caught in a sticky flag that stays set after the line drops, until software writes a 1 to its bit in the clear register. Every bit position is the same across status, mask, clear and pending: bits 0 to 4 are the fast group and bits 5 to 21 are the normal group. By default bits 3, 12 and 20 are end-of-interrupt sources.

A single register port has a write strobe, a 2-bit address and a combinational read path. The address map is 0 for status (read only), 1 for mask (read and write), 2 for end-of-interrupt clear (write only, reads as zero) and 3 for pending, which reads status AND mask.

Top module: `intc_dual_level`

## Requirements
- R1: Once synchronous reset is released, both request outputs are low and both the mask and status registers read zero.
- R2: A status bit for a level source follows its input one clock edge later, whether or not the source is enabled.
- R3: The fast request (fiq_o) goes high two edges after an enabled source in bits 0 to 4 becomes active, and one edge after a mask write enables an already active source. It falls with the same latency once no enabled fast source remains.
- R4: The normal request (irq_o) behaves the same way for bits 5 to 21.
- R5: A source whose mask bit is zero raises no request, but it still shows in status.
- R6: A fast-group source never drives irq_o, and a normal-group source never drives fiq_o.
- R7: The status bit of an end-of-interrupt source stays set after its input drops. Writing a 1 to that bit at address 2 clears the status bit at the write edge, and the request falls one edge later.
- R8: Clear writes have no effect on bits written as 0, and no effect on level sources.
- R9: If a clear arrives while an end-of-interrupt source is still active, the flag stays set.
- R10: A mask written at address 1 reads back unchanged. Address 3 reads status AND mask, and address 2 reads zero.
- R11: With several enabled sources active in one group, the request stays high until the last of them goes inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 22 | Interrupt source lines; bits 0-4 fast group, 5-21 normal group |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 clear, 3 pending |
| wdata_i | input | 22 | Register write data |
| rdata_o | output | 22 | Register read data for addr_i (combinational) |
| fiq_o | output | 1 | Fast interrupt request, registered |
| irq_o | output | 1 | Normal interrupt request, registered |

## Verification
A source change reaches status at the first edge and a request output at the second. A mask write takes effect at its own edge, so the request follows one edge later. A clear write empties the end-of-interrupt flag at its write edge and drops the request one edge after that. The bench drives inputs and samples outputs on falling edges and counts exactly those edges before each comparison. Wherever a register stage should make a result appear later, it also checks the old value one edge earlier.

// File: rtl/intc_pkg.sv
// Package: shared register address encoding for the interrupt aggregator.
// Assumes a 2-bit register address on the software port.
package intc_pkg;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_EOI    = 2'd2,
        REG_PEND   = 2'd3
    } intc_reg_e;

endpackage

// File: rtl/intc_src_stage.sv
// Source capture stage: one flop per source. A level source copies its
// input each edge. A source marked in LATCH_MASK sets a sticky flag that
// only a clear pulse resets, and an active input wins over a clear.
// Assumes src_i is already synchronous to clk.
module intc_src_stage #(
    parameter int                 N_SRC      = 22,
    parameter logic [N_SRC-1:0]   LATCH_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] eoi_clr_i,
    output logic [N_SRC-1:0] status_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic bit_q;
        if (LATCH_MASK[i]) begin : g_sticky
            // sticky end-of-interrupt flag; an active source overrides a clear
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= (bit_q & ~eoi_clr_i[i]) | src_i[i];
            end
        end else begin : g_level
            // plain level sample of the source line
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= src_i[i];
            end
        end
        assign status_o[i] = bit_q;
    end

endmodule

// File: rtl/intc_regport.sv
// Software register port: holds the mask register, decodes clear writes
// into a one-cycle pulse and muxes read data. Reads are combinational.
// Assumes a single write per cycle; writes to read-only addresses are dropped.
module intc_regport
    import intc_pkg::*;
#(
    parameter int N_SRC = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] status_i,
    output logic [N_SRC-1:0] mask_o,
    output logic [N_SRC-1:0] eoi_clr_o,
    output logic [N_SRC-1:0] rdata_o
);

    logic [N_SRC-1:0] mask_q;
    intc_reg_e        sel;

    assign sel = intc_reg_e'(addr_i);

    // mask register: cleared at reset, loaded by a write to REG_MASK
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '0;
        else if (wr_en_i && sel == REG_MASK) mask_q <= wdata_i;
    end

    // clear pulse: write data passed through only during a REG_EOI write
    always_comb begin
        eoi_clr_o = (wr_en_i && sel == REG_EOI) ? wdata_i : '0;
    end

    // read mux over the four addresses
    always_comb begin
        unique case (sel)
            REG_STATUS: rdata_o = status_i;
            REG_MASK:   rdata_o = mask_q;
            REG_EOI:    rdata_o = '0;
            REG_PEND:   rdata_o = status_i & mask_q;
            default:    rdata_o = '0;
        endcase
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/intc_req_reduce.sv
// Request reduction for one group: ANDs status with mask and ORs the
// result into a single registered request line, so the output is glitch-free.
// Assumes status and mask are both registered upstream.
module intc_req_reduce #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] mask_i,
    output logic         req_o
);

    logic req_q;

    // register the OR of enabled, active sources
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(status_i & mask_i);
    end

    assign req_o = req_q;

endmodule

// File: rtl/intc_dual_level.sv
// Top: two-group masked interrupt aggregator. Bits [N_FAST-1:0] form the
// fast group driving fiq_o; bits above form the normal group driving irq_o.
// Assumes synchronous sources and a synchronous active-low reset.
module intc_dual_level #(
    parameter int                           N_FAST     = 5,
    parameter int                           N_NORM     = 17,
    parameter logic [N_FAST+N_NORM-1:0]     LATCH_MASK = 22'h101008
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_FAST+N_NORM-1:0] src_i,
    input  logic                     wr_en_i,
    input  logic [1:0]               addr_i,
    input  logic [N_FAST+N_NORM-1:0] wdata_i,
    output logic [N_FAST+N_NORM-1:0] rdata_o,
    output logic                     fiq_o,
    output logic                     irq_o
);

    localparam int N_SRC = N_FAST + N_NORM;

    logic [N_SRC-1:0] status_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] eoi_clr;

    intc_src_stage #(
        .N_SRC      (N_SRC),
        .LATCH_MASK (LATCH_MASK)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .eoi_clr_i (eoi_clr),
        .status_o  (status_q)
    );

    intc_regport #(
        .N_SRC (N_SRC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .status_i  (status_q),
        .mask_o    (mask_q),
        .eoi_clr_o (eoi_clr),
        .rdata_o   (rdata_o)
    );

    intc_req_reduce #(
        .W (N_FAST)
    ) u_fast (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_q[N_FAST-1:0]),
        .mask_i   (mask_q[N_FAST-1:0]),
        .req_o    (fiq_o)
    );

    intc_req_reduce #(
        .W (N_NORM)
    ) u_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_q[N_SRC-1:N_FAST]),
        .mask_i   (mask_q[N_SRC-1:N_FAST]),
        .req_o    (irq_o)
    );

endmodule

// File: rtl/intc_dual_level_chk.sv
// Checker: temporal properties of the aggregator, bound into the top.
// Assumes it observes the top's status_q and mask_q registers.
module intc_dual_level_chk #(
    parameter int                       N_FAST     = 5,
    parameter int                       N_NORM     = 17,
    parameter logic [N_FAST+N_NORM-1:0] LATCH_MASK = 22'h101008
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     fiq_o,
    input logic                     irq_o,
    input logic [N_FAST+N_NORM-1:0] status_q,
    input logic [N_FAST+N_NORM-1:0] mask_q,
    input logic                     wr_en_i,
    input logic [1:0]               addr_i,
    input logic [N_FAST+N_NORM-1:0] wdata_i
);

    localparam int N_SRC = N_FAST + N_NORM;

    logic armed_q = 1'b0;
    logic rst_seen_q = 1'b0;

    // arm temporal checks one edge after reset is released
    always @(posedge clk) begin
        armed_q    <= rst_n;
        rst_seen_q <= !rst_n;
    end

    // reset leaves everything cleared
    always @(posedge clk) begin
        if (rst_seen_q && rst_n) begin
            // R1
            reset_clear_chk: assert (!fiq_o && !irq_o && mask_q == '0 && status_q == '0)
                else $error("reset state not clear");
        end
    end

    // R3
    fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        fiq_o == $past(|(status_q[N_FAST-1:0] & mask_q[N_FAST-1:0])));

    // R4
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        irq_o == $past(|(status_q[N_SRC-1:N_FAST] & mask_q[N_SRC-1:N_FAST])));

    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (wr_en_i && addr_i == 2'd1) |=> mask_q == $past(wdata_i));

    for (genvar i = 0; i < N_SRC; i++) begin : g_eoi
        if (LATCH_MASK[i]) begin : g_on
            // R7
            eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
                (status_q[i] && !(wr_en_i && addr_i == 2'd2 && wdata_i[i])) |=> status_q[i]);
        end
    end

endmodule

bind intc_dual_level intc_dual_level_chk #(
    .N_FAST     (N_FAST),
    .N_NORM     (N_NORM),
    .LATCH_MASK (LATCH_MASK)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fiq_o    (fiq_o),
    .irq_o    (irq_o),
    .status_q (status_q),
    .mask_q   (mask_q),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i)
);

// File: tb/intc_dual_level_bench.sv
// Directed bench: one task per scenario; inputs and samples on falling edges.
module intc_dual_level_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] src = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [21:0] wdata = '0;
    logic [21:0] rdata;
    logic        fiq, irq;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    intc_dual_level u_intc_dual_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .fiq_o   (fiq),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [21:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [21:0] d);
        addr = a; #1; d = rdata; addr = 2'd0;
    endtask

    task automatic t_reset();
        logic [21:0] d;
        rst_n = 1'b0; step(3); rst_n = 1'b1; step(1);
        chk("R1 fiq", fiq, 0);
        chk("R1 irq", irq, 0);
        rd(2'd1, d); chk("R1 mask", d, 0);
        rd(2'd0, d); chk("R1 status", d, 0);
    endtask

    task automatic t_regs();
        logic [21:0] d;
        wr(2'd1, 22'h2AAAAA);
        rd(2'd1, d); chk("R10 mask readback", d, 22'h2AAAAA);
        rd(2'd2, d); chk("R10 clear reads zero", d, 0);
        wr(2'd1, 22'h0);
    endtask

    task automatic t_fast();
        logic [21:0] d;
        wr(2'd1, 22'h3FFFFF);
        src[1] = 1'b1; step(1);
        rd(2'd0, d); chk("R2 status bit1", d, 22'h2);
        chk("R3 fiq not yet", fiq, 0);
        step(1);
        chk("R3 fiq high", fiq, 1);
        chk("R6 irq untouched by fast", irq, 0);
        src[1] = 1'b0; step(1);
        chk("R3 fiq still high", fiq, 1);
        step(1);
        chk("R3 fiq low", fiq, 0);
    endtask

    task automatic t_norm();
        src[9] = 1'b1; step(2);
        chk("R4 irq high", irq, 1);
        chk("R6 fiq untouched by normal", fiq, 0);
        src[9] = 1'b0; step(2);
        chk("R4 irq low", irq, 0);
    endtask

    task automatic t_masked();
        logic [21:0] d;
        wr(2'd1, 22'h0);
        src[7] = 1'b1; step(3);
        chk("R5 irq masked", irq, 0);
        rd(2'd0, d); chk("R5 status shows bit7", d, 22'h80);
        rd(2'd3, d); chk("R10 pending masked", d, 0);
        wr(2'd1, 22'h80);
        chk("R4 irq one edge after mask", irq, 0);
        rd(2'd3, d); chk("R10 pending bit7", d, 22'h80);
        step(1);
        chk("R4 irq after mask write", irq, 1);
        src[7] = 1'b0; step(2);
        chk("R4 irq drop", irq, 0);
        wr(2'd1, 22'h3FFFFF);
    endtask

    task automatic t_eoi();
        logic [21:0] d;
        src[12] = 1'b1; step(1); src[12] = 1'b0; step(4);
        rd(2'd0, d); chk("R7 latched bit12", d, 22'h1000);
        chk("R7 irq held", irq, 1);
        wr(2'd2, ~22'h1000);
        rd(2'd0, d); chk("R8 zero bit no clear", d, 22'h1000);
        wr(2'd2, 22'h1000);
        rd(2'd0, d); chk("R7 cleared", d, 0);
        chk("R7 irq lag", irq, 1);
        step(1);
        chk("R7 irq low", irq, 0);
    endtask

    task automatic t_eoi_held();
        logic [21:0] d;
        src[20] = 1'b1; step(2);
        wr(2'd2, 22'h100000);
        rd(2'd0, d); chk("R9 set survives clear", d, 22'h100000);
        src[20] = 1'b0; step(1);
        rd(2'd0, d); chk("R9 still latched", d, 22'h100000);
        wr(2'd2, 22'h100000);
        rd(2'd0, d); chk("R9 cleared after drop", d, 0);
        step(1);
    endtask

    task automatic t_level_clear();
        logic [21:0] d;
        src[9] = 1'b1; step(2);
        wr(2'd2, 22'h3FFFFF);
        rd(2'd0, d); chk("R8 level unaffected", d, 22'h200);
        chk("R8 irq stays", irq, 1);
        src[9] = 1'b0; step(2);
    endtask

    task automatic t_multi();
        src[5] = 1'b1; src[6] = 1'b1; step(2);
        chk("R11 irq two sources", irq, 1);
        src[5] = 1'b0; step(3);
        chk("R11 irq one left", irq, 1);
        src[6] = 1'b0; step(2);
        chk("R11 irq none", irq, 0);
    endtask

    initial begin
        step(1);
        t_reset();
        t_regs();
        t_fast();
        t_norm();
        t_masked();
        t_eoi();
        t_eoi_held();
        t_level_clear();
        t_multi();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule